// File: doc/BRIEF.md
# Event Performance Monitor Unit

This block counts activity of a processor core for profiling software. It holds three 32-bit counters: a dedicated cycle counter and two general counters. Each general counter has an 8-bit event code that picks its source: one line of a per-cycle core event vector, an external event-bus input, every clock, or nothing. A single global enable starts or stops all three counters together; there is no per-counter enable. Software parks a general counter by giving it the external-bus code while that input is held low.

Software reaches the block through a simple register port with one control/status word at address 0 and the three counters at addresses 1 to 3. A wrap from all-ones to zero sets a sticky overflow flag. The flags are cleared by writing ones, so writing back a word just read clears exactly the flags that were seen. One shared interrupt line reports any flag whose enable is set.

Top module: `evt_pmu`

## Requirements
- R1: After reset every register reads zero and irq_o is low.
- R2: While control bit 0 (global enable) is 0, no counter changes except by a direct counter write or a reset bit.
- R3: A control write with bit 1 set zeroes both general counters, and with bit 2 set zeroes the cycle counter and its prescaler. Either bit takes priority over an increment in the same cycle, and both bits read back as 0.
- R4: With control bit 3 clear, the cycle counter advances on every enabled clock. With bit 3 set, it advances once per 64 enabled clocks.
- R5: Counter 0 takes its event code from control bits 27:20 and counter 1 from bits 19:12. Code 0xFF counts every enabled clock, 0x20 counts clocks with ext_evt_i high, codes 0x00 to 0x12 count clocks with core_evt_i[code] high, and any other code counts nothing.
- R6: A counter that wraps from 0xFFFFFFFF to 0 sets its overflow flag. The flags are control bits 8 (counter 0), 9 (counter 1) and 10 (cycle counter), and each stays set until cleared.
- R7: A control write clears each flag whose written bit is 1 and leaves flags written with 0 untouched. A wrap in the same cycle as its clear leaves the flag set.
- R8: irq_o is high exactly when some flag is set together with its enable: bit 4 for counter 0, bit 5 for counter 1, bit 6 for the cycle counter.
- R9: A write to address 1 (cycle counter), 2 (counter 0) or 3 (counter 1) loads any value and wins over an increment in that cycle. A wrap that the write pre-empts sets no flag.
- R10: With reg_rd_i high, reg_rdata_o shows the addressed register in the same cycle, and it is zero otherwise. In the control word, bits 31:28, 11, 7 and 2:1 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 cycle, 2 counter 0, 3 counter 1 |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational |
| core_evt_i | input | NUM_CORE_EVT | Per-cycle core event pulses |
| ext_evt_i | input | 1 | External event-bus signal |
| irq_o | output | 1 | Shared overflow interrupt |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is an overflow flag being set by a wrap and the same flag being cleared by a write-one. The second pair is a counter increment meeting either a direct counter write or a reset bit. The bench preloads a counter with 0xFFFFFFFF and then, in the cycle of the wrap, issues the control write that clears that flag or the write that loads that counter. The flag is judged by reading the control word back, and the counter by reading its register back. Random traffic that keeps counters near the wrap point repeats these collisions, and a cycle-level reference model predicts every readback and irq_o.

// File: rtl/evt_pmu_pkg.sv
package evt_pmu_pkg;
  localparam int unsigned CNT_W   = 32;
  localparam int unsigned SEL_W   = 8;
  localparam int unsigned NUM_CNT = 3;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned FLAG_W  = NUM_CNT;

  localparam logic [SEL_W-1:0] CODE_CYCLES = 8'hFF;
  localparam logic [SEL_W-1:0] CODE_EXT    = 8'h20;

  // control word bit positions
  localparam int unsigned B_EN      = 0;
  localparam int unsigned B_RST_EVT = 1;
  localparam int unsigned B_RST_CYC = 2;
  localparam int unsigned B_DIV     = 3;
  localparam int unsigned B_IEN     = 4;
  localparam int unsigned B_OVF     = 8;
  localparam int unsigned B_SEL1    = 12;
  localparam int unsigned B_SEL0    = 20;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_CYC  = 2'd1,
    A_EVT0 = 2'd2,
    A_EVT1 = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pmu_evt_mux.sv
module pmu_evt_mux
  import evt_pmu_pkg::*;
#(
  parameter int unsigned NUM_EVT = 19
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_EVT-1:0] core_evt_i,
  input  logic               ext_evt_i,
  output logic               hit_o
);
  always_comb begin
    hit_o = 1'b0;
    if (sel_i == CODE_CYCLES) hit_o = 1'b1;
    else if (sel_i == CODE_EXT) hit_o = ext_evt_i;
    else begin
      for (int i = 0; i < NUM_EVT; i++)
        if (sel_i == SEL_W'(i)) hit_o = core_evt_i[i];
    end
  end
endmodule

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
  parameter int unsigned DIV_LOG2 = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic div_i,
  input  logic clr_i,
  output logic tick_o
);
  logic [DIV_LOG2-1:0] psc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            psc_q <= '0;
    else if (clr_i)         psc_q <= '0;
    else if (en_i && div_i) psc_q <= psc_q + 1'b1;
  end

  assign tick_o = en_i && (!div_i || (psc_q == '1));

  // no tick while the global enable is off
  assert_tick_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> en_i);
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wr_i)   cnt_q <= wdata_i;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = inc_i && !wr_i && !clr_i && (cnt_q == '1);

  assert_write_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_q == $past(wdata_i));
  assert_wrap_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> cnt_q == '0);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !wr_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/evt_pmu.sv
module evt_pmu
  import evt_pmu_pkg::*;
#(
  parameter int unsigned NUM_CORE_EVT = 19,
  parameter int unsigned DIV_LOG2     = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_wr_i,
  input  logic                    reg_rd_i,
  input  logic [ADDR_W-1:0]       reg_addr_i,
  input  logic [CNT_W-1:0]        reg_wdata_i,
  output logic [CNT_W-1:0]        reg_rdata_o,
  input  logic [NUM_CORE_EVT-1:0] core_evt_i,
  input  logic                    ext_evt_i,
  output logic                    irq_o
);
  logic              en_q, div_q;
  logic [FLAG_W-1:0] ien_q, ovf_q;   // flag order: cnt0, cnt1, cycle
  logic [SEL_W-1:0]  sel_q [2];
  logic              ctrl_wr;
  logic [NUM_CNT-1:0] inc, wrap;      // counter order: cycle, cnt0, cnt1
  logic [CNT_W-1:0]  cnt [NUM_CNT];
  logic [FLAG_W-1:0] w1c_mask, wrap_flag, ovf_d;

  assign ctrl_wr = reg_wr_i && (reg_addr_i == A_CTRL);

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    localparam int unsigned RST_BIT = (k == 0) ? B_RST_CYC : B_RST_EVT;
    logic cnt_wr, cnt_clr;
    assign cnt_wr  = reg_wr_i && (reg_addr_i == ADDR_W'(k + 1));
    assign cnt_clr = ctrl_wr && reg_wdata_i[RST_BIT];

    if (k == 0) begin : g_cyc
      pmu_prescaler #(.DIV_LOG2(DIV_LOG2)) u_psc (
        .clk_i (clk_i), .rst_ni(rst_ni), .en_i(en_q), .div_i(div_q),
        .clr_i (cnt_clr), .tick_o(inc[k])
      );
    end else begin : g_evt
      logic hit;
      pmu_evt_mux #(.NUM_EVT(NUM_CORE_EVT)) u_mux (
        .sel_i(sel_q[k-1]), .core_evt_i(core_evt_i), .ext_evt_i(ext_evt_i),
        .hit_o(hit)
      );
      assign inc[k] = en_q && hit;
    end

    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk_i (clk_i), .rst_ni(rst_ni), .wr_i(cnt_wr), .wdata_i(reg_wdata_i),
      .clr_i (cnt_clr), .inc_i(inc[k]), .cnt_o(cnt[k]), .wrap_o(wrap[k])
    );
  end

  assign wrap_flag = {wrap[0], wrap[2], wrap[1]};
  assign w1c_mask  = ctrl_wr ? reg_wdata_i[B_OVF +: FLAG_W] : '0;
  assign ovf_d     = (ovf_q & ~w1c_mask) | wrap_flag;  // set wins over clear

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      div_q    <= 1'b0;
      ien_q    <= '0;
      ovf_q    <= '0;
      sel_q[0] <= '0;
      sel_q[1] <= '0;
    end else begin
      ovf_q <= ovf_d;
      if (ctrl_wr) begin
        en_q     <= reg_wdata_i[B_EN];
        div_q    <= reg_wdata_i[B_DIV];
        ien_q    <= reg_wdata_i[B_IEN +: FLAG_W];
        sel_q[0] <= reg_wdata_i[B_SEL0 +: SEL_W];
        sel_q[1] <= reg_wdata_i[B_SEL1 +: SEL_W];
      end
    end
  end

  assign irq_o = |(ovf_q & ien_q);

  always_comb begin
    reg_rdata_o = '0;
    if (reg_rd_i) begin
      unique case (reg_addr_i)
        A_CTRL: begin
          reg_rdata_o[B_EN]               = en_q;
          reg_rdata_o[B_DIV]              = div_q;
          reg_rdata_o[B_IEN +: FLAG_W]    = ien_q;
          reg_rdata_o[B_OVF +: FLAG_W]    = ovf_q;
          reg_rdata_o[B_SEL1 +: SEL_W]    = sel_q[1];
          reg_rdata_o[B_SEL0 +: SEL_W]    = sel_q[0];
        end
        A_CYC:   reg_rdata_o = cnt[0];
        A_EVT0:  reg_rdata_o = cnt[1];
        default: reg_rdata_o = cnt[2];
      endcase
    end
  end

  assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(ovf_q) & ~$past(w1c_mask)) & ~ovf_q) == '0);
  assert_wrap_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wrap_flag) |=> (ovf_q & $past(wrap_flag)) == $past(wrap_flag));
  assert_irq_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|ovf_q));
  assert_rst_cyc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && reg_wdata_i[B_RST_CYC]) |=> cnt[0] == '0);
  assert_rst_evt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && reg_wdata_i[B_RST_EVT]) |=> (cnt[1] == '0 && cnt[2] == '0));
endmodule

// File: tb/tb_evt_pmu.sv
`timescale 1ns/1ps
module tb_evt_pmu;
  localparam int NEVT = 19;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0, ext = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [NEVT-1:0] core = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;

  evt_pmu dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .core_evt_i(core), .ext_evt_i(ext), .irq_o(irq)
  );

  always #2 clk = ~clk;

  // reference model: m_cnt 0 cycle, 1 cnt0, 2 cnt1; flags 0 cnt0, 1 cnt1, 2 cycle
  logic        m_en, m_div;
  logic [2:0]  m_ien, m_ovf;
  logic [7:0]  m_sel0, m_sel1;
  logic [31:0] m_cnt [3];
  logic [5:0]  m_psc;

  function automatic logic hit(logic [7:0] c);
    if (c == 8'hFF) return 1'b1;
    if (c == 8'h20) return ext;
    if (c < NEVT)   return core[c];
    return 1'b0;
  endfunction

  function automatic logic [31:0] m_ctrl();
    return {4'b0, m_sel0, m_sel1, 1'b0, m_ovf, 1'b0, m_ien, m_div, 2'b0, m_en};
  endfunction

  task automatic model_reset();
    m_en = 0; m_div = 0; m_ien = 0; m_ovf = 0; m_sel0 = 0; m_sel1 = 0; m_psc = 0;
    for (int k = 0; k < 3; k++) m_cnt[k] = 0;
  endtask

  task automatic model_step();
    logic [2:0] inc, wrp;
    logic cw, w, c;
    cw = wr && addr == 2'd0;
    inc[0] = m_en && (!m_div || m_psc == 6'h3F);
    inc[1] = m_en && hit(m_sel0);
    inc[2] = m_en && hit(m_sel1);
    wrp = 0;
    for (int k = 0; k < 3; k++) begin
      w = wr && addr == 2'(k + 1);
      c = cw && (k == 0 ? wdata[2] : wdata[1]);
      if (w) m_cnt[k] = wdata;
      else if (c) m_cnt[k] = 0;
      else if (inc[k]) begin
        if (m_cnt[k] == 32'hFFFF_FFFF) wrp[k] = 1;
        m_cnt[k] = m_cnt[k] + 1;
      end
    end
    if (cw && wdata[2]) m_psc = 0;
    else if (m_en && m_div) m_psc = m_psc + 1;
    m_ovf = (m_ovf & ~(cw ? wdata[10:8] : 3'b0)) | {wrp[0], wrp[2], wrp[1]};
    if (cw) begin
      m_en = wdata[0]; m_div = wdata[3]; m_ien = wdata[6:4];
      m_sel0 = wdata[27:20]; m_sel1 = wdata[19:12];
    end
  endtask

  task automatic check_all(string tag);
    logic [31:0] exp;
    wr = 0;
    for (int a = 0; a < 4; a++) begin
      rd = 1; addr = 2'(a); #0.1;
      exp = (a == 0) ? m_ctrl() : m_cnt[a-1];
      n_chk++;
      if (rdata !== exp) begin
        n_fail++;
        $display("FAIL %s addr %0d: got %h expected %h", tag, a, rdata, exp);
      end
    end
    rd = 0; #0.1;
    n_chk++;
    if (irq !== |(m_ovf & m_ien)) begin
      n_fail++;
      $display("FAIL %s R8 irq: got %b expected %b", tag, irq, |(m_ovf & m_ien));
    end
  endtask

  task automatic tick(string tag, logic w, logic [1:0] a, logic [31:0] d,
                      logic [NEVT-1:0] ce, logic ex);
    wr = w; addr = a; wdata = d; core = ce; ext = ex;
    @(posedge clk);
    model_step();
    #1;
    check_all(tag);
  endtask

  function automatic logic [31:0] ctl(logic en, logic [7:0] s0, logic [7:0] s1,
                                      logic [2:0] ien, logic [2:0] w1c,
                                      logic div, logic [1:0] rst);
    return {4'b0, s0, s1, 1'b0, w1c, 1'b0, ien, div, rst, en};
  endfunction

  function automatic logic [7:0] pick_code();
    case ($urandom % 5)
      0: return 8'hFF;
      1: return 8'h20;
      2: return 8'($urandom % NEVT);
      3: return 8'($urandom);
      default: return 8'($urandom % 8);
    endcase
  endfunction

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    #9; rst_n = 1; #1;
    check_all("R1");
    rd = 0; addr = 2'd2; #0.1; n_chk++;
    if (rdata !== 32'h0) begin
      n_fail++; $display("FAIL R10 idle rdata: got %h expected 0", rdata);
    end

    // R2: disabled, counters hold
    tick("R9", 1, 2'd2, 32'd5, '0, 0);
    tick("R2", 1, 2'd0, ctl(0, 8'hFF, 8'hFF, 0, 0, 0, 0), '1, 1);
    for (int i = 0; i < 5; i++) tick("R2", 0, 0, 0, '1, 1);

    // R5: core bit 3 on counter 0, ext on counter 1
    tick("R5", 1, 2'd0, ctl(1, 8'h03, 8'h20, 0, 0, 0, 0), '0, 0);
    for (int i = 0; i < 8; i++) tick("R5", 0, 0, 0, NEVT'(i[0] << 3), 0);
    for (int i = 0; i < 4; i++) tick("R5", 0, 0, 0, '0, i[0]);
    tick("R5", 1, 2'd0, ctl(1, 8'h13, 8'h12, 0, 0, 0, 0), '0, 0);
    for (int i = 0; i < 6; i++) tick("R5", 0, 0, 0, '1, 1);
    tick("R5", 1, 2'd0, ctl(1, 8'h20, 8'hFF, 0, 0, 0, 0), '0, 0);
    for (int i = 0; i < 3; i++) tick("R5", 0, 0, 0, '1, 0);

    // R6/R8: wrap of counter 0 sets bit 8 and raises irq
    tick("R9", 1, 2'd2, 32'hFFFF_FFFE, '0, 0);
    tick("R6", 1, 2'd0, ctl(1, 8'hFF, 8'h20, 3'b001, 0, 0, 0), '0, 0);
    for (int i = 0; i < 3; i++) tick("R6", 0, 0, 0, '0, 0);
    // R7: writing zero to the flag leaves it
    tick("R7", 1, 2'd0, ctl(1, 8'h20, 8'h20, 3'b001, 3'b000, 0, 0), '0, 0);
    tick("R8", 0, 0, 0, '0, 0);
    // R7: write back clears
    tick("R7", 1, 2'd0, ctl(1, 8'h20, 8'hFF, 3'b011, 3'b001, 0, 0), '0, 0);
    // R7 collision: wrap of counter 1 in the same cycle as its W1C
    tick("R9", 1, 2'd3, 32'hFFFF_FFFF, '0, 0);
    tick("R7", 1, 2'd0, ctl(1, 8'h20, 8'hFF, 3'b011, 3'b010, 0, 0), '0, 0);
    tick("R8", 0, 0, 0, '0, 0);
    // R9: write pre-empts a wrap, no flag
    tick("R7", 1, 2'd0, ctl(1, 8'h20, 8'hFF, 3'b111, 3'b111, 0, 0), '0, 0);
    tick("R9", 1, 2'd3, 32'hFFFF_FFFF, '0, 0);
    tick("R9", 1, 2'd3, 32'h1234_5678, '0, 0);
    tick("R9", 1, 2'd1, 32'hFFFF_FFFF, '0, 0);
    tick("R6", 0, 0, 0, '0, 0);
    // R3: reset bits while counting
    tick("R3", 1, 2'd0, ctl(1, 8'hFF, 8'hFF, 3'b111, 0, 0, 2'b11), '0, 0);
    tick("R3", 0, 0, 0, '0, 0);
    tick("R3", 1, 2'd0, ctl(1, 8'hFF, 8'hFF, 3'b111, 0, 0, 2'b01), '0, 0);
    tick("R3", 1, 2'd0, ctl(1, 8'hFF, 8'hFF, 3'b111, 0, 0, 2'b10), '0, 0);
    // R4: divider
    tick("R4", 1, 2'd0, ctl(1, 8'h20, 8'h20, 0, 3'b111, 1, 2'b10), '0, 0);
    for (int i = 0; i < 140; i++) tick("R4", 0, 0, 0, '0, 0);
    tick("R4", 1, 2'd0, ctl(1, 8'h20, 8'h20, 0, 0, 0, 0), '0, 0);
    for (int i = 0; i < 3; i++) tick("R4", 0, 0, 0, '0, 0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      logic [1:0] a;
      logic w;
      w = ($urandom % 4) == 0;
      a = 2'($urandom);
      d = $urandom;
      if (a == 2'd0) begin
        d[0] = ($urandom % 5) != 0;
        d[27:20] = pick_code();
        d[19:12] = pick_code();
        d[2:1] = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
        d[3] = ($urandom % 6) == 0;
      end else if ($urandom % 3 != 0) begin
        d = 32'hFFFF_FFF0 | 32'($urandom % 16);
      end
      tick("R7", w, a, d, NEVT'($urandom), 1'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule